// File: doc/BRIEF.md
# Two-Wire Slave Line Control with Start Detection and Clock Stretching

This block is the bit-level front end of a slave port on an I2C-compatible bus. It watches the wired SCL and SDA lines after synchronising them to the system clock. On every SCL rising edge it shifts the SDA value into a data register. It presents an output bit on SDA that changes only on SCL falling edges. A counter advances on every SCL edge in either direction. Both bus lines are open-drain: the block never drives high, it only asserts a pull-low enable per line, and its line inputs read the wired result.

The block recognises a start condition, which is SDA going low while SCL is high, and raises a start flag. On the first SCL falling edge after a start, it begins holding SCL low. This gives firmware time to prepare, and the hold lasts until the start flag is cleared by writing a one. When the edge counter wraps after a full byte (sixteen edges), an overflow flag is raised and SCL is likewise held low until that flag is cleared.

For an acknowledge bit, software preloads the counter two short of its wrap value before releasing the clock. The next single clock pulse then ends in a new overflow and a new hold. Address matching, stop detection and line filtering belong to the software or are absent.

Top module: `twi_phy_hold`

## Requirements
- R1: The start flag is set when synchronised SDA falls while synchronised SCL is high. An SDA fall while SCL is low leaves the flag at 0.
- R2: While the start flag is set, the SCL pull-low stays 0 until the first SCL falling edge after the start. From that edge on it is 1, so a released master clock still reads 0 on the bus.
- R3: A one-cycle pulse on start_clr_i clears the start flag and drops the start-induced SCL hold. A start detected in the same cycle takes priority.
- R4: On each SCL rising edge the data register shifts left by one, and the sampled SDA value enters bit 0. After eight clock pulses the register holds the byte sent, with the first bit sent in bit 7.
- R5: The counter increments on every SCL rising and falling edge. When it wraps from 15 to 0, the overflow flag is set and the SCL pull-low is 1. Both stay set until a one-cycle ovf_clr_i pulse. A counter value of 8 follows four clock pulses from 0.
- R6: With the counter loaded to 14, one clock pulse produces an overflow. After the rising edge the count is 15 and the overflow flag is 0. After the falling edge the count is 0 and the overflow flag is 1.
- R7: The SDA pull-low is 1 exactly when sda_oe_i is 1 and the output bit is 0. The output bit takes the data register's bit 7 when the register is written and on each SCL falling edge, but not on a rising edge.
- R8: After the data register is loaded with a byte and the master releases SDA, the bus carries the byte MSB first during each SCL high phase. After eight pulses the register holds the original byte again.
- R9: After reset both flags and both pull-low outputs are 0, the counter is 0 and the data register is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Wired SCL level read from the bus |
| sda_i | input | 1 | Wired SDA level read from the bus |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| sda_oe_i | input | 1 | Enables the SDA pull-low from the output bit |
| dr_wr_i | input | 1 | Loads the data register |
| dr_wdata_i | input | DATA_W | Value loaded into the data register |
| dr_q_o | output | DATA_W | Data register contents |
| cnt_wr_i | input | 1 | Loads the edge counter |
| cnt_wdata_i | input | CNT_W | Value loaded into the edge counter |
| cnt_q_o | output | CNT_W | Edge counter value |
| start_flag_o | output | 1 | Start condition seen |
| start_clr_i | input | 1 | Write-one clear of the start flag |
| ovf_flag_o | output | 1 | Counter wrapped |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |

## Verification
The assertions are checked on every cycle:
- The start flag can only rise out of an SDA fall seen while SCL was high.
- A new SCL hold that is not caused by an overflow begins right after an SCL falling edge.
- The data register moves only on a rising edge or a load.
- The SDA drive changes only on a falling edge, a load or an enable change.
- The overflow flag rises together with a zero count and stays set until it is cleared.

The values themselves are shown only by the bench's scenarios. These are: every byte value received and transmitted in loopback, the one-pulse acknowledge window from a preloaded count, the hold staying on while the master releases SCL, and the absence of a start flag for an SDA fall during SCL low.

// File: rtl/twi_phy_pkg.sv
package twi_phy_pkg;
   // one synchronised bus line: current and previous sampled level
   typedef struct packed {
      logic now;
      logic last;
   } line_t;

   function automatic logic line_rise(line_t l);
      return l.now & ~l.last;
   endfunction

   function automatic logic line_fall(line_t l);
      return ~l.now & l.last;
   endfunction
endpackage

// File: rtl/twi_line_pipe.sv
module twi_line_pipe
   import twi_phy_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  line_i,
   output line_t line_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_pipe: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q[s] <= 1'b1;
         end else if (s == 0) begin
            sync_q[s] <= line_i;
         end else begin
            sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= sync_q[STAGES-1];
   end

   assign line_o.now  = sync_q[STAGES-1];
   assign line_o.last = last_q;
endmodule

// File: rtl/twi_shift_count.sv
module twi_shift_count
   import twi_phy_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_t             scl,
   input  line_t             sda,
   input  logic              dr_wr,
   input  logic [DATA_W-1:0] dr_wdata,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              ovf_clr,
   output logic [DATA_W-1:0] dr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              ovf_flag,
   output logic              out_bit
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic scl_rise, scl_fall, scl_edge, wrap;

   assign scl_rise = line_rise(scl);
   assign scl_fall = line_fall(scl);
   assign scl_edge = scl_rise | scl_fall;
   assign wrap     = scl_edge & ~cnt_wr & (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (cnt_wr)   cnt_q <= cnt_wdata;
      else if (scl_edge) cnt_q <= cnt_q + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dr_q <= '1;
      else if (dr_wr)    dr_q <= dr_wdata;
      else if (scl_rise) dr_q <= {dr_q[DATA_W-2:0], sda.now};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_bit <= 1'b1;
      else if (dr_wr)    out_bit <= dr_wdata[DATA_W-1];
      else if (scl_fall) out_bit <= dr_q[DATA_W-1];
   end
endmodule

// File: rtl/twi_hold_ctl.sv
module twi_hold_ctl
   import twi_phy_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  line_t scl,
   input  line_t sda,
   input  logic  start_clr,
   output logic  start_flag,
   output logic  start_hold
);
   logic start_det, armed_q;

   assign start_det = line_fall(sda) & scl.now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         start_flag <= 1'b0;
      else if (start_det) start_flag <= 1'b1;
      else if (start_clr) start_flag <= 1'b0;
   end

   // arms on the first SCL fall after a start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              armed_q <= 1'b0;
      else if (start_det)                      armed_q <= 1'b0;
      else if (start_clr)                      armed_q <= 1'b0;
      else if (start_flag && line_fall(scl))   armed_q <= 1'b1;
   end

   assign start_hold = start_flag & armed_q;
endmodule

// File: rtl/twi_phy_hold.sv
module twi_phy_hold
   import twi_phy_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = $clog2(2*DATA_W),
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   input  logic              sda_oe_i,
   input  logic              dr_wr_i,
   input  logic [DATA_W-1:0] dr_wdata_i,
   output logic [DATA_W-1:0] dr_q_o,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   output logic [CNT_W-1:0]  cnt_q_o,
   output logic              start_flag_o,
   input  logic              start_clr_i,
   output logic              ovf_flag_o,
   input  logic              ovf_clr_i
);
   localparam int EDGES_PER_WORD = 2 * DATA_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("twi_phy_hold: DATA_W must be at least 2");
   end
   if ((1 << CNT_W) != EDGES_PER_WORD) begin : g_bad_cnt
      $error("twi_phy_hold: counter must wrap after 2*DATA_W edges");
   end

   line_t scl_ln, sda_ln;
   logic  start_hold, out_bit;

   twi_line_pipe #(.STAGES(SYNC_STAGES)) u_scl_pipe (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_ln));

   twi_line_pipe #(.STAGES(SYNC_STAGES)) u_sda_pipe (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_ln));

   twi_shift_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .scl(scl_ln), .sda(sda_ln),
      .dr_wr(dr_wr_i), .dr_wdata(dr_wdata_i),
      .cnt_wr(cnt_wr_i), .cnt_wdata(cnt_wdata_i), .ovf_clr(ovf_clr_i),
      .dr_q(dr_q_o), .cnt_q(cnt_q_o), .ovf_flag(ovf_flag_o),
      .out_bit(out_bit));

   twi_hold_ctl u_hold (
      .clk(clk), .rst_n(rst_n), .scl(scl_ln), .sda(sda_ln),
      .start_clr(start_clr_i), .start_flag(start_flag_o),
      .start_hold(start_hold));

   assign scl_pull_o = start_hold | ovf_flag_o;
   assign sda_pull_o = sda_oe_i & ~out_bit;
endmodule

// File: rtl/twi_phy_hold_chk.sv
module twi_phy_hold_chk
   import twi_phy_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input line_t             scl_ln,
   input line_t             sda_ln,
   input logic              scl_pull_o,
   input logic              sda_pull_o,
   input logic              sda_oe_i,
   input logic              dr_wr_i,
   input logic [DATA_W-1:0] dr_q_o,
   input logic [CNT_W-1:0]  cnt_q_o,
   input logic              start_flag_o,
   input logic              start_clr_i,
   input logic              ovf_flag_o,
   input logic              ovf_clr_i
);
   logic scl_rise, scl_fall, start_cond;
   assign scl_rise   = scl_ln.now & ~scl_ln.last;
   assign scl_fall   = ~scl_ln.now & scl_ln.last;
   assign start_cond = ~sda_ln.now & sda_ln.last & scl_ln.now;

   assert_start_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_flag_o) |-> $past(start_cond));

   assert_hold_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_pull_o) && !$rose(ovf_flag_o)) |-> (start_flag_o && $past(scl_fall)));

   assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_clr_i && !start_cond) |=> !start_flag_o);

   assert_shift_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dr_q_o) |-> $past(scl_rise || dr_wr_i));

   assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag_o) |-> (cnt_q_o == '0));

   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

   assert_sda_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_i && $past(sda_oe_i) && !$stable(sda_pull_o)) |-> $past(scl_fall || dr_wr_i));
endmodule

bind twi_phy_hold twi_phy_hold_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_ln(scl_ln), .sda_ln(sda_ln),
   .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .sda_oe_i(sda_oe_i),
   .dr_wr_i(dr_wr_i), .dr_q_o(dr_q_o), .cnt_q_o(cnt_q_o),
   .start_flag_o(start_flag_o), .start_clr_i(start_clr_i),
   .ovf_flag_o(ovf_flag_o), .ovf_clr_i(ovf_clr_i));

// File: tb/tb_twi_phy_hold.sv
module tb_twi_phy_hold;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int WDOG       = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       scl_pull, sda_pull;
   logic       sda_oe = 1'b0, dr_wr = 1'b0, cnt_wr = 1'b0;
   logic       start_clr = 1'b0, ovf_clr = 1'b0;
   logic [7:0] dr_wdata = '0, dr_q;
   logic [3:0] cnt_wdata = '0, cnt_q;
   logic       start_flag, ovf_flag;
   logic       scl_bus, sda_bus;
   int         n_chk = 0, n_fail = 0;

   assign scl_bus = m_scl & ~scl_pull;
   assign sda_bus = m_sda & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   twi_phy_hold dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .sda_oe_i(sda_oe),
      .dr_wr_i(dr_wr), .dr_wdata_i(dr_wdata), .dr_q_o(dr_q),
      .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cnt_q_o(cnt_q),
      .start_flag_o(start_flag), .start_clr_i(start_clr),
      .ovf_flag_o(ovf_flag), .ovf_clr_i(ovf_clr));

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one-cycle software access while SCL is low
   task automatic sw(bit wr_dr, logic [7:0] drv, bit wr_cnt, logic [3:0] cv,
                     bit c_ovf, bit c_start);
      @(negedge clk);
      dr_wr = wr_dr; dr_wdata = drv; cnt_wr = wr_cnt; cnt_wdata = cv;
      ovf_clr = c_ovf; start_clr = c_start;
      @(negedge clk);
      dr_wr = 1'b0; cnt_wr = 1'b0; ovf_clr = 1'b0; start_clr = 1'b0;
   endtask

   initial begin
      wt(WDOG);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wt(4);
      rst_n = 1'b1;
      wt(2);
      chk("R9 start flag", start_flag, 0);
      chk("R9 ovf flag", ovf_flag, 0);
      chk("R9 scl pull", scl_pull, 0);
      chk("R9 sda pull", sda_pull, 0);
      chk("R9 count", cnt_q, 0);
      chk("R9 data", dr_q, 8'hFF);

      // SDA fall during SCL low is not a start
      m_scl = 1'b0; wt(HALF);
      m_sda = 1'b0; wt(HALF);
      chk("R1 no start when SCL low", start_flag, 0);
      m_sda = 1'b1; wt(HALF);
      m_scl = 1'b1; wt(HALF);

      // real start
      m_sda = 1'b0; wt(HALF);
      chk("R1 start flag", start_flag, 1);
      chk("R2 no hold before fall", scl_pull, 0);
      m_scl = 1'b0; wt(HALF);
      chk("R2 hold after fall", scl_pull, 1);
      m_scl = 1'b1; wt(HALF);
      chk("R2 bus held low", scl_bus, 0);
      m_scl = 1'b0;
      sw(0, 8'h00, 1, 4'd0, 0, 1);
      wt(HALF);
      chk("R3 start cleared", start_flag, 0);
      chk("R3 hold released", scl_pull, 0);

      // receive every byte value
      for (int v = 0; v < 256; v++) begin
         for (int i = 0; i < 8; i++) begin
            m_sda = v[7-i]; wt(HALF);
            m_scl = 1'b1; wt(HALF);
            m_scl = 1'b0; wt(HALF);
            if (v == 8'h5A && i == 3) chk("R5 count after 4 pulses", cnt_q, 8);
         end
         chk("R4 received byte", dr_q, v);
         chk("R5 ovf flag", ovf_flag, 1);
         chk("R5 scl held", scl_pull, 1);
         chk("R5 count wrapped", cnt_q, 0);
         if (v == 8'hC3) begin
            m_scl = 1'b1; wt(HALF);
            chk("R5 bus held while released", scl_bus, 0);
            m_scl = 1'b0; wt(HALF);
            // acknowledge slot
            m_sda = 1'b1;
            sda_oe = 1'b1;
            sw(1, 8'h00, 1, 4'd14, 1, 0);
            wt(HALF);
            chk("R7 ack pulls sda", sda_bus, 0);
            chk("R6 ovf cleared", ovf_flag, 0);
            m_scl = 1'b1; wt(HALF);
            chk("R6 count after rise", cnt_q, 15);
            chk("R6 no ovf after rise", ovf_flag, 0);
            m_scl = 1'b0; wt(HALF);
            chk("R6 count after fall", cnt_q, 0);
            chk("R6 ovf after pulse", ovf_flag, 1);
            sda_oe = 1'b0; wt(2);
            chk("R7 oe off releases sda", sda_pull, 0);
         end
         sw(0, 8'h00, 1, 4'd0, 1, 0);
         wt(2);
         chk("R5 ovf clear releases", scl_pull, 0);
      end

      // transmit every byte value, master released
      m_sda = 1'b1;
      for (int v = 0; v < 256; v++) begin
         sda_oe = 1'b1;
         sw(1, v[7:0], 1, 4'd0, 1, 0);
         wt(HALF);
         for (int i = 0; i < 8; i++) begin
            m_scl = 1'b1; wt(HALF);
            chk("R8 bit on bus", sda_bus, v[7-i]);
            m_scl = 1'b0; wt(HALF);
         end
         chk("R8 loopback", dr_q, v);
         chk("R5 ovf after tx", ovf_flag, 1);
      end
      sda_oe = 1'b0;
      sw(1, 8'h00, 0, 4'd0, 1, 0);
      wt(2);
      chk("R7 zero bit without oe", sda_pull, 0);
      sda_oe = 1'b1; wt(2);
      chk("R7 zero bit with oe", sda_pull, 1);
      sda_oe = 1'b0; wt(2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule